// File: doc/BRIEF.md
# Lane-Preserving Thread Compactor

This block takes one active-thread mask for a whole thread block and turns it into a short stream of compacted warps. Each thread has a fixed home lane: thread `t` (0-based) lives in lane `t mod LANES` and occupies row `t / LANES` of that lane. A separate selector per lane picks one active thread from that lane's column for every warp produced. A thread is never moved to another lane, so a warp has an empty slot wherever its lane has no work left.

A caller pulses `start` with the mask while the block is idle. The block then offers warps on a valid/ready output. A warp is accepted on a clock edge where `out_valid` and `out_ready` are both high. Only an accepted warp removes its threads from the internal mask. While `out_valid` is high and `out_ready` is low, the offered warp is held unchanged, and `out_valid` never drops without a transfer. After the last warp is accepted, the block pulses `done` for one cycle and returns to idle. It leaves the number of warps it formed on `warp_count`.

Top module: `lane_thread_compactor`

## Requirements
- R1: After reset, `out_valid`, `done` and `warp_count` are all zero.
- R2: Slot `l` of a warp carries only a thread whose ID satisfies `tid mod LANES == l`. The thread ID is `row*LANES + lane`, counted from 0. Slot `l` occupies bits `l*TID_W +: TID_W` of `out_tid`.
- R3: In each warp, every lane offers its lowest-numbered thread that is still pending. A lane with nothing pending shows 0 in its bit of `out_slot_vld`. An offered warp always has at least one valid slot.
- R4: The number of warps accepted equals the largest count of active threads in any one lane. `done` is high for exactly one cycle, in the cycle after the edge that accepts the last warp. At that point `warp_count` holds this number, and it keeps holding it until the next accepted `start`.
- R5: For a mask with every bit set, warp `k` carries threads `k*LANES + l` in every slot `l`, with all slots valid. This is the static warp arrangement.
- R6: An all-zero mask produces no warp at all. `done` appears in the cycle right after the `start` edge, with `warp_count` equal to 0.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_slot_vld` and `out_tid` stay unchanged.
- R8: A `start` pulse that arrives while warps are still being produced is ignored. The remaining warps come from the original mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Loads `mask_in` when the block is idle |
| mask_in | input | LANES*ROWS | Active mask for the thread block; bit t is thread t |
| out_valid | output | 1 | A compacted warp is offered |
| out_ready | input | 1 | The warp buffer accepts the offered warp |
| out_slot_vld | output | LANES | Per-lane slot occupied flags |
| out_tid | output | LANES*TID_W | Per-lane thread IDs, lane l at bits l*TID_W +: TID_W |
| done | output | 1 | One-cycle pulse when a mask has been fully compacted |
| warp_count | output | CNT_W | Number of warps formed for the last mask |

## Verification
A selector that picked the wrong row would show up at the ports on the first warp that carries that lane. It would appear as an unexpected thread ID, or as a thread repeated in a later warp. A mask bit that was not cleared, or that was cleared too early, changes the number of warps. That shows up at `done`, either one cycle late or one cycle early, and as a wrong `warp_count`. A hand-off that lets state move under back-pressure changes the held warp within one stalled cycle. A reload while busy changes the sequence at the next offered warp.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  typedef enum logic [0:0] {
    CMP_IDLE = 1'b0,
    CMP_RUN  = 1'b1
  } cmp_state_e;
endpackage

// File: rtl/ltc_lane_pick.sv
module ltc_lane_pick #(
  parameter int ROWS  = 3,
  parameter int LANES = 4,
  parameter int LANE  = 0,
  parameter int TID_W = 4
) (
  input  logic [ROWS-1:0]  column,
  output logic             found,
  output logic [ROWS-1:0]  pick_onehot,
  output logic [TID_W-1:0] pick_tid
);
  always_comb begin
    found       = 1'b0;
    pick_onehot = '0;
    pick_tid    = '0;
    for (int r = ROWS - 1; r >= 0; r--) begin
      if (column[r]) begin
        found       = 1'b1;
        pick_onehot = ROWS'(1) << r;
        pick_tid    = TID_W'(r * LANES + LANE);
      end
    end
  end
endmodule

// File: rtl/ltc_mask_bank.sv
module ltc_mask_bank #(
  parameter int BITS = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  input  logic            clr_en,
  input  logic [BITS-1:0] clr_bits,
  output logic [BITS-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      mask_q <= '0;
    else if (load)   mask_q <= load_val;
    else if (clr_en) mask_q <= mask_q & ~clr_bits;
  end
endmodule

// File: rtl/ltc_warp_tally.sv
module ltc_warp_tally #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)     count <= '0;
    else if (clear) count <= '0;
    else if (inc)   count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/lane_thread_compactor.sv
module lane_thread_compactor #(
  parameter int LANES = 4,
  parameter int ROWS  = 3,
  localparam int THREADS = LANES * ROWS,
  localparam int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int CNT_W   = $clog2(ROWS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [THREADS-1:0]       mask_in,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANES-1:0]         out_slot_vld,
  output logic [LANES*TID_W-1:0]   out_tid,
  output logic                     done,
  output logic [CNT_W-1:0]         warp_count
);
  import ltc_pkg::*;

  cmp_state_e          st_q;
  logic [THREADS-1:0]  mask_q;
  logic [THREADS-1:0]  clr_bits;
  logic                take_start;
  logic                fire;
  logic                last_fire;
  logic                done_q;

  assign take_start = start && (st_q == CMP_IDLE);
  assign out_valid  = (st_q == CMP_RUN) && (|mask_q);
  assign fire       = out_valid && out_ready;
  assign last_fire  = fire && ((mask_q & ~clr_bits) == '0);

  ltc_mask_bank #(.BITS(THREADS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take_start),
    .load_val (mask_in),
    .clr_en   (fire),
    .clr_bits (clr_bits),
    .mask_q   (mask_q)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ROWS-1:0] column;
    logic [ROWS-1:0] onehot;
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign column[r]              = mask_q[r*LANES + l];
      assign clr_bits[r*LANES + l]  = onehot[r];
    end
    ltc_lane_pick #(.ROWS(ROWS), .LANES(LANES), .LANE(l), .TID_W(TID_W)) u_pick (
      .column      (column),
      .found       (out_slot_vld[l]),
      .pick_onehot (onehot),
      .pick_tid    (out_tid[l*TID_W +: TID_W])
    );

    // R2: an occupied slot only ever holds a thread homed on that lane
    p_lane_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_slot_vld[l] |-> ((int'(out_tid[l*TID_W +: TID_W]) % LANES) == l));
  end

  ltc_warp_tally #(.CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (take_start),
    .inc   (fire),
    .count (warp_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= CMP_IDLE;
      done_q <= 1'b0;
    end else begin
      done_q <= (take_start && (mask_in == '0)) || last_fire;
      if (take_start && (mask_in != '0)) st_q <= CMP_RUN;
      else if (last_fire)                st_q <= CMP_IDLE;
    end
  end

  assign done = done_q;

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_slot_vld) && $stable(out_tid)));

  p_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_slot_vld) > 0));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    warp_count <= CNT_W'(ROWS));

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid);
endmodule

// File: tb/lane_thread_compactor_bench.sv
module lane_thread_compactor_bench;
  localparam int LANES = 4;
  localparam int ROWS  = 3;
  localparam int N     = LANES * ROWS;
  localparam int TW    = $clog2(N);
  localparam int CW    = $clog2(ROWS + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [N-1:0]    mask_in = '0;
  logic            out_valid;
  logic            out_ready = 1'b0;
  logic [LANES-1:0]    out_slot_vld;
  logic [LANES*TW-1:0] out_tid;
  logic            done;
  logic [CW-1:0]   warp_count;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  lane_thread_compactor #(.LANES(LANES), .ROWS(ROWS)) u_lane_thread_compactor (
    .clk(clk), .rst_n(rst_n), .start(start), .mask_in(mask_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_slot_vld(out_slot_vld),
    .out_tid(out_tid), .done(done), .warp_count(warp_count)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // stall: 0 = always ready, otherwise ready once every 'stall' cycles
  // intrude: a mask pulsed on start at cycle 1 of the run (0 = none)
  task automatic run_case(input logic [N-1:0] m, input int stall, input logic [N-1:0] intrude,
                          input string req);
    int exp_tid [ROWS][LANES];
    bit exp_v   [ROWS][LANES];
    int exp_n = 0;
    logic [N-1:0] left = m;
    int w = 0;
    int last_c = -1;
    int done_c = -1;
    bit prev_stall = 0;
    logic [LANES-1:0] prev_v = '0;
    logic [LANES*TW-1:0] prev_t = '0;
    for (int k = 0; k < ROWS; k++) begin
      bit any = 0;
      for (int l = 0; l < LANES; l++) begin
        exp_v[k][l] = 0; exp_tid[k][l] = 0;
        for (int r = 0; r < ROWS; r++) begin
          if (!exp_v[k][l] && left[r*LANES + l]) begin
            exp_v[k][l] = 1; exp_tid[k][l] = r*LANES + l;
            left[r*LANES + l] = 1'b0; any = 1;
          end
        end
      end
      if (any) exp_n++;
    end
    @(negedge clk);
    start = 1'b1; mask_in = m;
    @(negedge clk);
    start = 1'b0; mask_in = '0;
    for (int c = 0; c < 60; c++) begin
      out_ready = (stall == 0) ? 1'b1 : ((c % stall) == (stall - 1));
      if (c == 1 && intrude != '0) begin start = 1'b1; mask_in = intrude; end
      else begin start = 1'b0; mask_in = '0; end
      #1;
      if (prev_stall) begin
        chk(out_valid == 1'b1, "R7", "valid held", int'(out_valid), 1);
        chk(out_slot_vld == prev_v && out_tid == prev_t, "R7", "warp held", int'(out_tid), int'(prev_t));
      end
      if (done) begin done_c = c; break; end
      if (out_valid) begin
        if (out_ready) begin
          if (w < ROWS) begin
            for (int l = 0; l < LANES; l++) begin
              chk(out_slot_vld[l] == exp_v[w][l], req, "slot valid", int'(out_slot_vld[l]), int'(exp_v[w][l]));
              if (exp_v[w][l]) begin
                chk(int'(out_tid[l*TW +: TW]) == exp_tid[w][l], req, "slot tid", int'(out_tid[l*TW +: TW]), exp_tid[w][l]);
                chk(int'(out_tid[l*TW +: TW]) % LANES == l, "R2", "home lane", int'(out_tid[l*TW +: TW]) % LANES, l);
              end
            end
          end
          w++; last_c = c;
        end
        prev_stall = !out_ready;
        prev_v = out_slot_vld; prev_t = out_tid;
      end else prev_stall = 0;
      @(negedge clk);
    end
    start = 1'b0; mask_in = '0; out_ready = 1'b0;
    chk(w == exp_n, "R4", "warps accepted", w, exp_n);
    chk(done_c == last_c + 1, "R4", "done cycle", done_c, last_c + 1);
    chk(int'(warp_count) == exp_n, "R4", "warp_count", int'(warp_count), exp_n);
    @(negedge clk);
    chk(done == 1'b0, "R4", "done one cycle", int'(done), 0);
    chk(int'(warp_count) == exp_n, "R4", "count held", int'(warp_count), exp_n);
    chk(out_valid == 1'b0, "R4", "idle after done", int'(out_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "reset valid", int'(out_valid), 0);
    chk(done == 1'b0, "R1", "reset done", int'(done), 0);
    chk(warp_count == '0, "R1", "reset count", int'(warp_count), 0);
  endtask

  task automatic t_example();   // threads 0,1,4,6,7,10,11 -> {0,1,6,7},{4,-,10,11}
    run_case(12'b1100_1101_0011, 0, '0, "R3");
  endtask

  task automatic t_dense();
    run_case({N{1'b1}}, 0, '0, "R5");
  endtask

  task automatic t_zero();
    run_case('0, 0, '0, "R6");
    chk(warp_count == '0, "R6", "zero count", int'(warp_count), 0);
  endtask

  task automatic t_one_lane();  // lane 2 only, all rows
    run_case(12'b0100_0100_0100, 0, '0, "R3");
  endtask

  task automatic t_backpressure();
    run_case(12'b1011_0110_1101, 3, '0, "R7");
  endtask

  task automatic t_busy_start();
    run_case(12'b0001_0010_1000, 2, 12'b1111_0000_0001, "R8");
  endtask

  task automatic t_single();
    run_case(12'b1000_0000_0000, 0, '0, "R3");
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_example();
    t_dense();
    t_zero();
    t_one_lane();
    t_backpressure();
    t_busy_start();
    t_single();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule